// File: doc/BRIEF.md
# Shift-Add Odd-Part Rotator with Root-Half Scaler

This block performs the constant-coefficient rotation found in the odd half of an eight-point scaled inverse cosine transform, using only shifts and additions. Two signed operands, g6 and g7, are rotated by the angle pair cos(π/8) and cos(3π/8). The block returns h6 = g7·cos(π/8) − g6·cos(3π/8) and h7 = g6·cos(π/8) + g7·cos(3π/8). Both cosines are held as fixed-point fractions over 2^17. Each input is expanded once into a small set of shared partial terms, and both products for that input are taken from those terms.

A separate lane multiplies a third signed operand by about √2/2, that is 46341/65536, with a four-add, four-shift chain. The block can be built purely combinational, or with one output register stage and a valid flag so it can sit inside a pipelined one-dimensional transform. The operand width is a parameter. The internal and output width is two bits wider than the input.

Top module: `sr_rotator`

## Requirements
- R1: h6_o equals C1(g7_i) − C3(g6_i), where C1 and C3 are defined in R3 and R4, bit-exact.
- R2: h7_o equals C1(g6_i) + C3(g7_i), bit-exact.
- R3: For an input g, the partial terms are p = g − (g>>4), q = p + (g>>3) and r = p + (q>>10). The cos(3π/8) product is C3(g) = (g>>1) − (r>>3).
- R4: The cos(π/8) product is C1(g) = r − (p>>6), using the same p and r as R3.
- R5: half_o equals s + (v>>6) with u = a + (a>>2), w = u>>2, s = a − w and v = u + (w>>6). For example, a = 1024 gives 724.
- R6: Every right shift is arithmetic and rounds toward minus infinity. For example, g6 = −1 and g7 = 0 give h6 = 0 and h7 = −1, and a = −1 gives half = −1.
- R7: The outputs are IN_W+2 bits wide and signed. With both inputs at the most positive or the most negative value, h6 and h7 stay exact and have magnitude below 2^IN_W.
- R8: When MODE is MODE_REG, the results for inputs sampled with in_vld high appear on the outputs one clock later, and out_vld is in_vld delayed by one clock.
- R9: When MODE is MODE_REG, a synchronous active-high reset clears out_vld, h6_o, h7_o and half_o to zero.
- R10: When MODE is MODE_REG and in_vld is low, the data outputs keep their previous values whatever the inputs do.
- R11: When MODE is MODE_COMB, the outputs follow the inputs in the same cycle with no register, and out_vld equals in_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input operands are valid |
| g6_i | input | IN_W | Signed rotation operand g6 |
| g7_i | input | IN_W | Signed rotation operand g7 |
| a_i | input | IN_W | Signed operand of the root-half lane |
| out_vld | output | 1 | Outputs are valid |
| h6_o | output | IN_W+2 | Signed rotated output h6 |
| h7_o | output | IN_W+2 | Signed rotated output h7 |
| half_o | output | IN_W+2 | Signed a·√2/2 approximation |

## Verification
The bench builds two copies of the block. The first uses IN_W = 16 with MODE_REG, which exercises the one-cycle latency, the reset state, the hold while in_vld is low, and full-scale 16-bit operands where overflow of h7 would first show. The second uses IN_W = 12 with MODE_COMB. It receives the same vectors scaled down, so the narrower internal word and the same-cycle path are checked against the same expected arithmetic.

// File: rtl/sr_pkg.sv
package sr_pkg;

    // Output stage variant
    typedef enum logic {
        MODE_COMB = 1'b0,
        MODE_REG  = 1'b1
    } sr_mode_e;

    // Shift amounts of the shared cosine partial-term chain
    localparam int unsigned SH_P  = 4;   // p = g - (g >> SH_P)
    localparam int unsigned SH_Q  = 3;   // q = p + (g >> SH_Q)
    localparam int unsigned SH_R  = 10;  // r = p + (q >> SH_R)
    localparam int unsigned SH_C3 = 1;   // C3 = (g >> SH_C3) - (r >> SH_C3R)
    localparam int unsigned SH_C3R = 3;
    localparam int unsigned SH_C1 = 6;   // C1 = r - (p >> SH_C1)

    // Shift amounts of the root-half chain
    localparam int unsigned SH_U  = 2;   // u = a + (a >> SH_U)
    localparam int unsigned SH_W  = 2;   // w = u >> SH_W
    localparam int unsigned SH_V  = 6;   // v = u + (w >> SH_V)
    localparam int unsigned SH_Y  = 6;   // y = s + (v >> SH_Y)

    // Guard bits added to the operand width inside the datapath
    localparam int unsigned GUARD = 2;

endpackage

// File: rtl/sr_cos_terms.sv
module sr_cos_terms
    import sr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic signed [W-1:0] g,
    output logic signed [W-1:0] c1,
    output logic signed [W-1:0] c3
);

    logic signed [W-1:0] p;
    logic signed [W-1:0] q;
    logic signed [W-1:0] r;

    always_comb begin
        p  = g - (g >>> SH_P);
        q  = p + (g >>> SH_Q);
        r  = p + (q >>> SH_R);
        c3 = (g >>> SH_C3) - (r >>> SH_C3R);
        c1 = r - (p >>> SH_C1);
    end

endmodule

// File: rtl/sr_root_half.sv
module sr_root_half
    import sr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic signed [W-1:0] a,
    output logic signed [W-1:0] y
);

    logic signed [W-1:0] u;
    logic signed [W-1:0] w;
    logic signed [W-1:0] s;
    logic signed [W-1:0] v;

    always_comb begin
        u = a + (a >>> SH_U);
        w = u >>> SH_W;
        s = a - w;
        v = u + (w >>> SH_V);
        y = s + (v >>> SH_Y);
    end

endmodule

// File: rtl/sr_out_stage.sv
module sr_out_stage
    import sr_pkg::*;
#(
    parameter int unsigned DW   = 54,
    parameter sr_mode_e    MODE = MODE_REG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          d_vld,
    input  logic [DW-1:0] d,
    output logic          q_vld,
    output logic [DW-1:0] q
);

    generate
        if (MODE == MODE_REG) begin : g_reg
            logic          vld_r;
            logic [DW-1:0] dat_r;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_r <= 1'b0;
                    dat_r <= '0;
                end else begin
                    vld_r <= d_vld;
                    if (d_vld) begin
                        dat_r <= d;
                    end
                end
            end

            assign q_vld = vld_r;
            assign q     = dat_r;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign q_vld = d_vld;
            assign q     = d;
        end
    endgenerate

endmodule

// File: rtl/sr_rotator.sv
module sr_rotator
    import sr_pkg::*;
#(
    parameter int unsigned IN_W = 16,
    parameter sr_mode_e    MODE = MODE_REG
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [IN_W-1:0]   g6_i,
    input  logic signed [IN_W-1:0]   g7_i,
    input  logic signed [IN_W-1:0]   a_i,
    output logic                     out_vld,
    output logic signed [IN_W+1:0]   h6_o,
    output logic signed [IN_W+1:0]   h7_o,
    output logic signed [IN_W+1:0]   half_o
);

    localparam int unsigned IW    = IN_W + GUARD;
    localparam int unsigned NLANE = 3;
    localparam int unsigned DW    = NLANE * IW;

    typedef struct packed {
        logic signed [IW-1:0] h6;
        logic signed [IW-1:0] h7;
        logic signed [IW-1:0] half;
    } sr_res_t;

    logic signed [IW-1:0] g6_x;
    logic signed [IW-1:0] g7_x;
    logic signed [IW-1:0] a_x;

    assign g6_x = IW'(g6_i);
    assign g7_x = IW'(g7_i);
    assign a_x  = IW'(a_i);

    logic signed [IW-1:0] c1_g6;
    logic signed [IW-1:0] c3_g6;
    logic signed [IW-1:0] c1_g7;
    logic signed [IW-1:0] c3_g7;
    logic signed [IW-1:0] half_c;

    sr_cos_terms #(.W(IW)) u_terms_g6 (
        .g  (g6_x),
        .c1 (c1_g6),
        .c3 (c3_g6)
    );

    sr_cos_terms #(.W(IW)) u_terms_g7 (
        .g  (g7_x),
        .c1 (c1_g7),
        .c3 (c3_g7)
    );

    sr_root_half #(.W(IW)) u_half (
        .a (a_x),
        .y (half_c)
    );

    sr_res_t res_c;
    sr_res_t res_q;

    always_comb begin
        res_c.h6   = c1_g7 - c3_g6;
        res_c.h7   = c1_g6 + c3_g7;
        res_c.half = half_c;
    end

    logic [DW-1:0] res_q_bits;

    sr_out_stage #(.DW(DW), .MODE(MODE)) u_out (
        .clk   (clk),
        .rst   (rst),
        .d_vld (in_vld),
        .d     (res_c),
        .q_vld (out_vld),
        .q     (res_q_bits)
    );

    assign res_q  = sr_res_t'(res_q_bits);
    assign h6_o   = res_q.h6;
    assign h7_o   = res_q.h7;
    assign half_o = res_q.half;

endmodule

// File: rtl/sr_rotator_chk.sv
module sr_rotator_chk
    import sr_pkg::*;
#(
    parameter int unsigned IN_W = 16,
    parameter sr_mode_e    MODE = MODE_REG
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_vld,
    input logic signed [IN_W-1:0] g6_i,
    input logic signed [IN_W-1:0] g7_i,
    input logic                   out_vld,
    input logic signed [IN_W+1:0] h6_o,
    input logic signed [IN_W+1:0] h7_o,
    input logic signed [IN_W+1:0] half_o
);

    localparam logic signed [IN_W+1:0] BND  = {2'b01, {IN_W{1'b0}}};
    localparam logic signed [IN_W+1:0] HBND = {3'b001, {(IN_W-1){1'b0}}};

    // R7: rotated outputs never reach 2^IN_W in magnitude
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (h6_o < BND) && (h6_o > -BND) && (h7_o < BND) && (h7_o > -BND));

    // R5: root-half result magnitude stays within half of full scale
    a_r5_half_bound: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (half_o <= HBND) && (half_o >= -HBND));

    generate
        if (MODE == MODE_REG) begin : g_reg_chk
            // R8: valid is delayed by exactly one clock
            a_r8_vld_delay: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> out_vld == $past(in_vld));

            // R9: reset clears valid and data
            a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !out_vld && h6_o == '0 && h7_o == '0 && half_o == '0);

            // R10: data holds while valid is low
            a_r10_hold: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(in_vld)) |-> $stable(h6_o) && $stable(h7_o) && $stable(half_o));

            // R2: non-negative operands give a non-negative h7 one cycle later
            a_r2_sign: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_vld) && $past(g6_i >= 0) && $past(g7_i >= 0)) |-> h7_o >= 0);
        end else begin : g_comb_chk
            // R2: non-negative operands give a non-negative h7 in the same cycle
            a_r2_sign_comb: assert property (@(posedge clk) disable iff (rst)
                (in_vld && g6_i >= 0 && g7_i >= 0) |-> h7_o >= 0);
        end
    endgenerate

endmodule

bind sr_rotator sr_rotator_chk #(.IN_W(IN_W), .MODE(MODE)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .g6_i    (g6_i),
    .g7_i    (g7_i),
    .out_vld (out_vld),
    .h6_o    (h6_o),
    .h7_o    (h7_o),
    .half_o  (half_o)
);

// File: tb/sr_rotator_tb_top.sv
module sr_rotator_tb_top;
    import sr_pkg::*;

    localparam int unsigned W_R = 16;
    localparam int unsigned W_C = 12;
    localparam int NV = 12;

    // g6, g7, a
    localparam int TBL [0:NV-1][0:2] = '{
        '{0, 0, 0},
        '{1000, 0, 1000},
        '{0, 1000, -1000},
        '{1234, -4321, 777},
        '{-5000, 3000, -32768},
        '{32767, 32767, 32767},
        '{-32768, -32768, -32768},
        '{32767, -32768, 1},
        '{-32768, 32767, -2},
        '{7, 8, 9},
        '{-17, -129, -1025},
        '{20000, 12345, 16384}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [W_R-1:0] g6_r = '0, g7_r = '0, a_r = '0;
    logic signed [W_C-1:0] g6_c = '0, g7_c = '0, a_c = '0;
    logic out_vld_r, out_vld_c;
    logic signed [W_R+1:0] h6_r, h7_r, half_r;
    logic signed [W_C+1:0] h6_c, h7_c, half_c;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sr_rotator #(.IN_W(W_R), .MODE(MODE_REG)) dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .g6_i(g6_r), .g7_i(g7_r), .a_i(a_r),
        .out_vld(out_vld_r), .h6_o(h6_r), .h7_o(h7_r), .half_o(half_r)
    );

    sr_rotator #(.IN_W(W_C), .MODE(MODE_COMB)) dut_c (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .g6_i(g6_c), .g7_i(g7_c), .a_i(a_c),
        .out_vld(out_vld_c), .h6_o(h6_c), .h7_o(h7_c), .half_o(half_c)
    );

    // Model of R3/R4 and R5 in plain integers
    function automatic int m_c3(input int g);
        int p, q, r;
        p = g - (g >>> 4);
        q = p + (g >>> 3);
        r = p + (q >>> 10);
        return (g >>> 1) - (r >>> 3);
    endfunction

    function automatic int m_c1(input int g);
        int p, q, r;
        p = g - (g >>> 4);
        q = p + (g >>> 3);
        r = p + (q >>> 10);
        return r - (p >>> 6);
    endfunction

    function automatic int m_half(input int a);
        int u, w, s, v;
        u = a + (a >>> 2);
        w = u >>> 2;
        s = a - w;
        v = u + (w >>> 6);
        return s + (v >>> 6);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one vector; check the comb copy at once and the registered copy a cycle later
    task automatic apply(input int g6, input int g7, input int a);
        int g6s, g7s, as;
        g6s = g6 >>> 4;
        g7s = g7 >>> 4;
        as  = a >>> 4;
        @(negedge clk);
        in_vld = 1'b1;
        g6_r = W_R'(g6); g7_r = W_R'(g7); a_r = W_R'(a);
        g6_c = W_C'(g6s); g7_c = W_C'(g7s); a_c = W_C'(as);
        #1;
        chk("R11 vld", int'(out_vld_c), 1);
        chk("R1/R11 h6 comb", int'(h6_c), m_c1(g7s) - m_c3(g6s));
        chk("R2/R11 h7 comb", int'(h7_c), m_c1(g6s) + m_c3(g7s));
        chk("R5/R11 half comb", int'(half_c), m_half(as));
        @(negedge clk);
        chk("R8 vld", int'(out_vld_r), 1);
        chk("R1 R3 R4 h6", int'(h6_r), m_c1(g7) - m_c3(g6));
        chk("R2 R3 R4 h7", int'(h7_r), m_c1(g6) + m_c3(g7));
        chk("R5 half", int'(half_r), m_half(a));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int h6_hold, h7_hold, half_hold;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 vld", int'(out_vld_r), 0);
        chk("R9 h6", int'(h6_r), 0);
        chk("R9 h7", int'(h7_r), 0);
        chk("R9 half", int'(half_r), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 vld idle", int'(out_vld_r), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i][0], TBL[i][1], TBL[i][2]);
        end

        // R5: hand value
        apply(0, 0, 1024);
        chk("R5 a=1024", int'(half_r), 724);

        // R6: floor rounding of negative unit inputs
        apply(-1, 0, -1);
        chk("R6 h6", int'(h6_r), 0);
        chk("R6 h7", int'(h7_r), -1);
        chk("R6 half", int'(half_r), -1);
        apply(0, -1, 0);
        chk("R6 h6 g7=-1", int'(h6_r), -1);
        chk("R6 h7 g7=-1", int'(h7_r), 0);

        // R7: full-scale magnitude below 2^16
        apply(32767, 32767, 0);
        chk("R7 h7 bound", int'(h7_r < 65536 && h7_r > -65536), 1);
        apply(-32768, -32768, 0);
        chk("R7 h7 neg bound", int'(h7_r < 65536 && h7_r > -65536), 1);
        h6_hold = int'(h6_r);
        h7_hold = int'(h7_r);
        half_hold = int'(half_r);

        // R10: inputs change while in_vld low, outputs hold
        @(negedge clk);
        in_vld = 1'b0;
        g6_r = 16'sd300; g7_r = 16'sd400; a_r = 16'sd500;
        @(negedge clk);
        chk("R8 vld low", int'(out_vld_r), 0);
        chk("R11 vld low", int'(out_vld_c), 0);
        @(negedge clk);
        chk("R10 h6 hold", int'(h6_r), h6_hold);
        chk("R10 h7 hold", int'(h7_r), h7_hold);
        chk("R10 half hold", int'(half_r), half_hold);

        // R9: reset in mid-run clears outputs
        in_vld = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid vld", int'(out_vld_r), 0);
        chk("R9 mid h7", int'(h7_r), 0);
        rst = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule